// File: doc/BRIEF.md
# Instruction Exception Classifier

This block looks at each fetched 16-bit instruction word, along with its first extension word and the current privilege mode, and decides in one registered step what happens next. The instruction may run. It may be handed to the floating-point path. Or it may be stopped with an exception, in which case the block gives the exception's vector number and a class code. Three separate trap sources share one prioritized result: undefined encodings, the reserved emulation line (top nibble 4'hA), and privileged instructions seen in user mode. A breakpoint-acknowledge bus cycle that has finished also forces the illegal-instruction result, and it overrides every other source.

The set of legal opcode lines is a reduced map chosen by a parameter mask. The vector numbers, the accepted control-register ranges and the word reserved as always-illegal are parameters too. Generate switches decide whether the emulation line and the floating-point line are recognised, or whether each of them counts as illegal.

Top module: `insn_exc_classifier`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is 0.
- R2: Each output reflects the inputs sampled on the previous rising edge. `res_valid` is 1 exactly one cycle after a cycle with `insn_valid` or `bkpt_done` high. When both were low, `exc_req`, `exec_en` and `fp_route` are 0.
- R3: A valid word is illegal and gives `exc_req`=1, `exc_vector`=4 and `exc_kind`=1 in either of two cases. The first is that its top nibble is not one of the legal lines in the default mask, which holds lines 0-6, 8, 9 and B-E. The second is that the word equals 16'h4AFC.
- R4: A valid word whose bits 15..12 equal 4'hA gives `exc_req`=1, `exc_vector`=10 and `exc_kind`=2, whatever the privilege mode.
- R5: A valid word whose bits 15..12 equal 4'hF and that is not one of the privileged encodings of R8 gives `fp_route`=1, `exc_req`=0 and `exec_en`=0.
- R6: A control-register move is a word that matches 16'h4E7A with bit 0 ignored. If the low 12 bits of its extension word are outside 12'h000-12'h007 and also outside 12'h800-12'h807, it is illegal: vector 4, kind 1, in both privilege modes.
- R7: `bkpt_done` high gives `exc_req`=1, vector 4 and kind 1 on the next cycle, whatever opcode, valid or mode was present.
- R8: With `supervisor`=0, a valid privileged word gives vector 8 and kind 3. The privileged words are: 16'h007C, 16'h027C and 16'h0A7C; a match to 16'h40C0 or 16'h46C0 under mask 16'hFFC0; a match to 16'h4E60 under mask 16'hFFF0; 16'h4E70, 16'h4E72 and 16'h4E73; a control-register move with a defined register; and a match to 16'hF400 under mask 16'hFE00.
- R9: With `supervisor`=1, a privileged word gives `exec_en`=1 and `exc_req`=0. A valid legal word that is not privileged gives `exec_en`=1 in either mode.
- R10: At most one of `exc_req`, `exec_en` and `fp_route` is 1. `exc_req` is 1 exactly when `exc_kind` is non-zero, and `exc_vector` is 0 when `exc_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Opcode and extension word are present this cycle |
| opcode | input | 16 | Instruction word |
| ext_word | input | 16 | First extension word |
| supervisor | input | 1 | 1 = supervisor mode, 0 = user mode |
| bkpt_done | input | 1 | Breakpoint-acknowledge cycle ended (acknowledge or error) |
| res_valid | output | 1 | A classification result is present |
| exc_req | output | 1 | Exception requested |
| exc_vector | output | 8 | Exception vector number, 0 when no exception |
| exc_kind | output | 2 | 0 none, 1 illegal, 2 emulation line, 3 privilege |
| exec_en | output | 1 | Instruction may execute |
| fp_route | output | 1 | Word handed to the floating-point path |

## Verification
The assertions assume that `opcode`, `ext_word` and `supervisor` are driven to known values on every cycle in which `insn_valid` is high. They also assume that `bkpt_done` is a one-cycle indication that may arrive together with a valid word. The bench drives every input at the falling edge and never leaves an input unknown. Random words are biased toward the privileged encodings, the control-register move and extension values near the edges of the accepted ranges. Breakpoint terminations are mixed into valid and idle cycles.

// File: rtl/ixc_pkg.sv
package ixc_pkg;
   typedef enum logic [1:0] {
      EXC_NONE    = 2'd0,
      EXC_ILLEGAL = 2'd1,
      EXC_EMUL    = 2'd2,
      EXC_PRIV    = 2'd3
   } exc_kind_e;

   localparam int OPW = 16;
   localparam int NLINE = 16;
endpackage

// File: rtl/ixc_line_decode.sv
module ixc_line_decode #(
   parameter logic [15:0] LEGAL_LINES  = 16'h7B7F,
   parameter logic [15:0] ILLEGAL_WORD = 16'h4AFC,
   parameter bit          EMUL_EN      = 1'b1
) (
   input  logic [15:0] opcode,
   output logic        line_illegal,
   output logic        line_emul,
   output logic        line_f
);
   localparam logic [3:0] EMUL_LINE = 4'hA;
   localparam logic [3:0] FP_LINE   = 4'hF;

   logic [3:0] line;
   logic       is_a;
   logic       map_bad;

   assign line   = opcode[15:12];
   assign is_a   = (line == EMUL_LINE);
   assign line_f = (line == FP_LINE);

   // The mask covers lines other than the emulation and floating-point ones
   assign map_bad = !is_a && !line_f && !LEGAL_LINES[line];

   generate
      if (EMUL_EN) begin : g_emul
         assign line_emul    = is_a;
         assign line_illegal = map_bad || (opcode == ILLEGAL_WORD);
      end else begin : g_no_emul
         assign line_emul    = 1'b0;
         assign line_illegal = map_bad || is_a || (opcode == ILLEGAL_WORD);
      end
   endgenerate
endmodule

// File: rtl/ixc_priv_check.sv
module ixc_priv_check #(
   parameter int          CTRL_LO_CNT  = 8,
   parameter logic [11:0] CTRL_HI_BASE = 12'h800,
   parameter int          CTRL_HI_CNT  = 8
) (
   input  logic [15:0] opcode,
   input  logic [15:0] ext_word,
   output logic        priv_hit,
   output logic        ctrl_bad
);
   localparam int NPAT = 10;
   localparam logic [15:0] PVAL [NPAT] = '{
      16'h007C, 16'h027C, 16'h0A7C, 16'h40C0, 16'h46C0,
      16'h4E60, 16'h4E70, 16'h4E72, 16'h4E73, 16'hF400 };
   localparam logic [15:0] PMSK [NPAT] = '{
      16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFC0, 16'hFFC0,
      16'hFFF0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFE00 };
   localparam logic [15:0] CTRL_VAL = 16'h4E7A;
   localparam logic [15:0] CTRL_MSK = 16'hFFFE;
   localparam logic [12:0] LO_END = 13'(CTRL_LO_CNT);
   localparam logic [12:0] HI_END = 13'(CTRL_HI_BASE) + 13'(CTRL_HI_CNT);

   generate
      if (CTRL_LO_CNT < 1 || CTRL_LO_CNT > 2048) begin : g_bad_lo
         $error("CTRL_LO_CNT out of range");
      end
      if (CTRL_HI_CNT < 1 || HI_END > 13'h1000) begin : g_bad_hi
         $error("control register high range exceeds field");
      end
   endgenerate

   logic [NPAT-1:0] hits;
   logic            is_ctrl;
   logic [12:0]     reg_sel;
   logic            reg_ok;

   generate
      for (genvar i = 0; i < NPAT; i++) begin : g_pat
         assign hits[i] = ((opcode & PMSK[i]) == PVAL[i]);
      end
   endgenerate

   assign is_ctrl  = ((opcode & CTRL_MSK) == CTRL_VAL);
   assign reg_sel  = {1'b0, ext_word[11:0]};
   assign reg_ok   = (reg_sel < LO_END) ||
                     ((reg_sel >= 13'(CTRL_HI_BASE)) && (reg_sel < HI_END));
   assign ctrl_bad = is_ctrl && !reg_ok;
   assign priv_hit = (|hits) || is_ctrl;
endmodule

// File: rtl/ixc_prio_reg.sv
module ixc_prio_reg
   import ixc_pkg::*;
#(
   parameter int          VW          = 8,
   parameter logic [VW-1:0] VEC_ILLEGAL = 8'd4,
   parameter logic [VW-1:0] VEC_EMUL    = 8'd10,
   parameter logic [VW-1:0] VEC_PRIV    = 8'd8,
   parameter bit          FP_EN       = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          insn_valid,
   input  logic          bkpt_done,
   input  logic          supervisor,
   input  logic          line_illegal,
   input  logic          line_emul,
   input  logic          line_f,
   input  logic          priv_hit,
   input  logic          ctrl_bad,
   output logic          res_valid,
   output logic          exc_req,
   output logic [VW-1:0] exc_vector,
   output logic [1:0]    exc_kind,
   output logic          exec_en,
   output logic          fp_route
);
   exc_kind_e  kind_d;
   logic       fp_cand;
   logic       fp_d;
   logic       fp_bad;
   logic       exec_d;
   logic [VW-1:0] vec_d;

   assign fp_cand = line_f && !priv_hit;

   generate
      if (FP_EN) begin : g_fp
         assign fp_bad = 1'b0;
      end else begin : g_no_fp
         assign fp_bad = fp_cand;
      end
   endgenerate

   always_comb begin
      kind_d = EXC_NONE;
      fp_d   = 1'b0;
      exec_d = 1'b0;
      if (bkpt_done) begin
         kind_d = EXC_ILLEGAL;
      end else if (insn_valid) begin
         if (line_emul)                          kind_d = EXC_EMUL;
         else if (fp_cand && !fp_bad)            fp_d   = 1'b1;
         else if (line_illegal || ctrl_bad || fp_bad) kind_d = EXC_ILLEGAL;
         else if (priv_hit && !supervisor)       kind_d = EXC_PRIV;
         else                                    exec_d = 1'b1;
      end
   end

   always_comb begin
      unique case (kind_d)
         EXC_ILLEGAL: vec_d = VEC_ILLEGAL;
         EXC_EMUL:    vec_d = VEC_EMUL;
         EXC_PRIV:    vec_d = VEC_PRIV;
         default:     vec_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         exc_req    <= 1'b0;
         exc_vector <= '0;
         exc_kind   <= 2'd0;
         exec_en    <= 1'b0;
         fp_route   <= 1'b0;
      end else begin
         res_valid  <= insn_valid || bkpt_done;
         exc_req    <= (kind_d != EXC_NONE);
         exc_vector <= vec_d;
         exc_kind   <= kind_d;
         exec_en    <= exec_d;
         fp_route   <= fp_d;
      end
   end

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exc_req, exec_en, fp_route}));
   p_vec_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |-> (exc_vector == '0 && exc_kind == 2'd0));
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid || bkpt_done) |=> res_valid);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(insn_valid || bkpt_done) |=> !(exc_req || exec_en || fp_route));
   p_bkpt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_done |=> (exc_req && exc_vector == VEC_ILLEGAL));
   p_user_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && priv_hit && !supervisor) |=> !exec_en);
endmodule

// File: rtl/insn_exc_classifier.sv
module insn_exc_classifier #(
   parameter int          VW           = 8,
   parameter logic [15:0] LEGAL_LINES  = 16'h7B7F,
   parameter logic [15:0] ILLEGAL_WORD = 16'h4AFC,
   parameter bit          EMUL_EN      = 1'b1,
   parameter bit          FP_EN        = 1'b1,
   parameter int          CTRL_LO_CNT  = 8,
   parameter logic [11:0] CTRL_HI_BASE = 12'h800,
   parameter int          CTRL_HI_CNT  = 8,
   parameter logic [VW-1:0] VEC_ILLEGAL = 8'd4,
   parameter logic [VW-1:0] VEC_EMUL    = 8'd10,
   parameter logic [VW-1:0] VEC_PRIV    = 8'd8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          insn_valid,
   input  logic [15:0]   opcode,
   input  logic [15:0]   ext_word,
   input  logic          supervisor,
   input  logic          bkpt_done,
   output logic          res_valid,
   output logic          exc_req,
   output logic [VW-1:0] exc_vector,
   output logic [1:0]    exc_kind,
   output logic          exec_en,
   output logic          fp_route
);
   generate
      if (VW < 4) begin : g_bad_vw
         $error("VW too narrow for vector numbers");
      end
      if (VEC_ILLEGAL == '0 || VEC_EMUL == '0 || VEC_PRIV == '0) begin : g_bad_vec
         $error("vector 0 is reserved for no exception");
      end
   endgenerate

   logic line_illegal, line_emul, line_f, priv_hit, ctrl_bad;

   ixc_line_decode #(
      .LEGAL_LINES (LEGAL_LINES),
      .ILLEGAL_WORD(ILLEGAL_WORD),
      .EMUL_EN     (EMUL_EN)
   ) line_i (
      .opcode      (opcode),
      .line_illegal(line_illegal),
      .line_emul   (line_emul),
      .line_f      (line_f)
   );

   ixc_priv_check #(
      .CTRL_LO_CNT (CTRL_LO_CNT),
      .CTRL_HI_BASE(CTRL_HI_BASE),
      .CTRL_HI_CNT (CTRL_HI_CNT)
   ) priv_i (
      .opcode  (opcode),
      .ext_word(ext_word),
      .priv_hit(priv_hit),
      .ctrl_bad(ctrl_bad)
   );

   ixc_prio_reg #(
      .VW         (VW),
      .VEC_ILLEGAL(VEC_ILLEGAL),
      .VEC_EMUL   (VEC_EMUL),
      .VEC_PRIV   (VEC_PRIV),
      .FP_EN      (FP_EN)
   ) prio_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .insn_valid  (insn_valid),
      .bkpt_done   (bkpt_done),
      .supervisor  (supervisor),
      .line_illegal(line_illegal),
      .line_emul   (line_emul),
      .line_f      (line_f),
      .priv_hit    (priv_hit),
      .ctrl_bad    (ctrl_bad),
      .res_valid   (res_valid),
      .exc_req     (exc_req),
      .exc_vector  (exc_vector),
      .exc_kind    (exc_kind),
      .exec_en     (exec_en),
      .fp_route    (fp_route)
   );

   p_emul_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (EMUL_EN && insn_valid && !bkpt_done && opcode[15:12] == 4'hA)
      |=> (exc_vector == VEC_EMUL && exc_kind == 2'd2));
   p_fp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fp_route |-> $past(opcode[15:12] == 4'hF));
endmodule

// File: tb/insn_exc_classifier_tb.sv
`timescale 1ns/1ps
module insn_exc_classifier_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [15:0] opcode = '0;
   logic [15:0] ext_word = '0;
   logic        supervisor = 1'b0;
   logic        bkpt_done = 1'b0;
   logic        res_valid, exc_req, exec_en, fp_route;
   logic [7:0]  exc_vector;
   logic [1:0]  exc_kind;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   insn_exc_classifier dut_i (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .opcode(opcode),
      .ext_word(ext_word), .supervisor(supervisor), .bkpt_done(bkpt_done),
      .res_valid(res_valid), .exc_req(exc_req), .exc_vector(exc_vector),
      .exc_kind(exc_kind), .exec_en(exec_en), .fp_route(fp_route)
   );

   function automatic bit is_ctrl(input logic [15:0] op);
      return (op[15:1] == 15'h273D);
   endfunction

   function automatic bit ctrl_ok(input logic [15:0] ext);
      return (ext[11:0] < 12'h008) || (ext[11:0] >= 12'h800 && ext[11:0] < 12'h808);
   endfunction

   function automatic bit is_priv(input logic [15:0] op);
      return op == 16'h007C || op == 16'h027C || op == 16'h0A7C ||
             (op & 16'hFFC0) == 16'h40C0 || (op & 16'hFFC0) == 16'h46C0 ||
             (op & 16'hFFF0) == 16'h4E60 || op == 16'h4E70 ||
             op == 16'h4E72 || op == 16'h4E73 || is_ctrl(op) ||
             (op & 16'hFE00) == 16'hF400;
   endfunction

   // returns {valid, kind[1:0], fp, exec}
   function automatic logic [4:0] model(input logic [15:0] op, input logic [15:0] ext,
                                        input bit sup, input bit v, input bit bk);
      logic [15:0] legal = 16'h7B7F;
      logic [3:0]  ln = op[15:12];
      if (bk) return {1'b1, 2'd1, 2'b00};
      if (!v) return 5'b0;
      if (ln == 4'hA) return {1'b1, 2'd2, 2'b00};
      if (ln == 4'hF && !is_priv(op)) return {1'b1, 2'd0, 2'b10};
      if ((ln != 4'hF && !legal[ln]) || op == 16'h4AFC || (is_ctrl(op) && !ctrl_ok(ext)))
         return {1'b1, 2'd1, 2'b00};
      if (is_priv(op) && !sup) return {1'b1, 2'd3, 2'b00};
      return {1'b1, 2'd0, 2'b01};
   endfunction

   function automatic string tag_of(input logic [15:0] op, input logic [15:0] ext,
                                    input bit sup, input bit v, input bit bk);
      logic [4:0] m = model(op, ext, sup, v, bk);
      if (bk) return "R7";
      if (!v) return "R2";
      if (m[3:2] == 2'd2) return "R4";
      if (m[1]) return "R5";
      if (is_ctrl(op) && !ctrl_ok(ext)) return "R6";
      if (m[3:2] == 2'd1) return "R3";
      if (m[3:2] == 2'd3) return "R8";
      if (is_priv(op)) return "R9";
      return "R9";
   endfunction

   task automatic step(input logic [15:0] op, input logic [15:0] ext,
                       input bit sup, input bit v, input bit bk);
      logic [4:0] m;
      logic [7:0] ev;
      string t;
      m = model(op, ext, sup, v, bk);
      t = tag_of(op, ext, sup, v, bk);
      ev = (m[3:2] == 2'd1) ? 8'd4 : (m[3:2] == 2'd2) ? 8'd10 :
           (m[3:2] == 2'd3) ? 8'd8 : 8'd0;
      insn_valid = v; opcode = op; ext_word = ext; supervisor = sup; bkpt_done = bk;
      @(negedge clk);
      total++;
      if ({res_valid, exc_kind, fp_route, exec_en} !== m || exc_vector !== ev ||
          exc_req !== (m[3:2] != 2'd0)) begin
         bad++;
         $display("FAIL %s op=%h ext=%h sup=%0d v=%0d bk=%0d: got vld=%0d req=%0d vec=%0d kind=%0d fp=%0d ex=%0d, exp vld=%0d req=%0d vec=%0d kind=%0d fp=%0d ex=%0d",
                  t, op, ext, sup, v, bk, res_valid, exc_req, exc_vector, exc_kind,
                  fp_route, exec_en, m[4], (m[3:2] != 2'd0), ev, m[3:2], m[1], m[0]);
      end
      total++;
      if ($countones({exc_req, exec_en, fp_route}) > 1 ||
          (exc_req !== (exc_kind != 2'd0)) || (!exc_req && exc_vector != 8'd0)) begin
         bad++;
         $display("FAIL R10 req=%0d ex=%0d fp=%0d kind=%0d vec=%0d, exp at most one set and vec 0 when idle",
                  exc_req, exec_en, fp_route, exc_kind, exc_vector);
      end
   endtask

   initial begin : watchdog
      #(5ns * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [15:0] privs [8];
      void'($urandom(32'h1C0FFEE));
      privs = '{16'h007C, 16'h0A7C, 16'h40C5, 16'h46FF, 16'h4E6B, 16'h4E72, 16'h4E7B, 16'hF4A8};
      repeat (3) @(negedge clk);
      total++;
      if ({res_valid, exc_req, exc_vector, exc_kind, exec_en, fp_route} !== '0) begin
         bad++;
         $display("FAIL R1 outputs in reset: got %b, exp 0",
                  {res_valid, exc_req, exc_vector, exc_kind, exec_en, fp_route});
      end
      rst_n = 1'b1;
      @(negedge clk);
      total++;
      if ({res_valid, exc_req, exec_en, fp_route} !== 4'b0) begin
         bad++;
         $display("FAIL R1 first cycle after reset: got %b, exp 0000",
                  {res_valid, exc_req, exec_en, fp_route});
      end
      // directed corners
      step(16'h1234, 16'h0, 1'b0, 1'b1, 1'b0);   // R9 plain legal
      step(16'h1234, 16'h0, 1'b0, 1'b0, 1'b0);   // R2 idle
      step(16'h7001, 16'h0, 1'b1, 1'b1, 1'b0);   // R3 line 7
      step(16'h4AFC, 16'h0, 1'b1, 1'b1, 1'b0);   // R3 reserved word
      step(16'hA123, 16'h0, 1'b1, 1'b1, 1'b0);   // R4
      step(16'hA000, 16'h0, 1'b0, 1'b1, 1'b0);   // R4 user
      step(16'hF200, 16'h0, 1'b0, 1'b1, 1'b0);   // R5
      step(16'hF400, 16'h0, 1'b0, 1'b1, 1'b0);   // R8 cache op user
      step(16'hF5FF, 16'h0, 1'b1, 1'b1, 1'b0);   // R9 cache op supervisor
      step(16'h4E7A, 16'h0008, 1'b1, 1'b1, 1'b0); // R6 just past low range
      step(16'h4E7B, 16'h0808, 1'b0, 1'b1, 1'b0); // R6 just past high range
      step(16'h4E7A, 16'h07FF, 1'b1, 1'b1, 1'b0); // R6 just below high range
      step(16'h4E7A, 16'hF007, 1'b1, 1'b1, 1'b0); // R9 top bits ignored
      step(16'h4E7B, 16'h0800, 1'b0, 1'b1, 1'b0); // R8
      step(16'h4E73, 16'h0, 1'b0, 1'b1, 1'b0);   // R8
      step(16'h4E71, 16'h0, 1'b0, 1'b1, 1'b0);   // R9 not privileged
      step(16'hA123, 16'h0, 1'b0, 1'b0, 1'b1);   // R7 alone
      step(16'hA123, 16'h0, 1'b0, 1'b1, 1'b1);   // R7 overrides R4
      step(16'h007C, 16'h0, 1'b0, 1'b1, 1'b1);   // R7 overrides R8
      // random
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] op, ext;
         int sel;
         sel = $urandom_range(0, 9);
         op  = 16'($urandom);
         if (sel < 3) op = privs[$urandom_range(0, 7)];
         else if (sel == 3) op = {15'h273D, 1'($urandom)};
         ext = 16'($urandom);
         if ($urandom_range(0, 1) == 0)
            ext[11:0] = {$urandom_range(0, 1) ? 4'h8 : 4'h0, 4'h0, 4'($urandom_range(4, 11))};
         step(op, ext, 1'($urandom), $urandom_range(0, 7) != 0, $urandom_range(0, 15) == 0);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule